// File: doc/BRIEF.md
# Line Voltage Sag and Zero-Crossing Monitor

This block watches a stream of signed voltage samples, one per sample strobe. It marks the start of each positive half of the line waveform on a zero-cross output. It splits the waveform into half cycles at every sign change and records the largest magnitude seen in each one. When enough consecutive half cycles stay below a programmable level, it pulls an active-low sag output down.

A second path checks that the line is present at all. A countdown is loaded at every positive-going crossing and steps down once per time-base tick. If it reaches zero before the next crossing, the line is treated as lost and the sag output is also pulled low. Two sticky status flags record that a sag was entered and that the crossing timeout ran out. They stay set until a clear strobe.

Top module: `line_sag_monitor`

## Requirements
- R1: `zx_out` goes to 1 in the cycle after a sample strobe whose sample is non-negative (sign bit 0) and follows a negative sample (sign bit 1). It goes to 0 in the cycle after a strobe whose negative sample follows a non-negative one. The first sample after reset never counts as a crossing.
- R2: A half cycle ends at every sign change between consecutive strobed samples. The value judged is the largest absolute value among the samples of that half cycle, not the last one. It is compared against the threshold `sag_level << (SAMPLE_W-1-LEVEL_W)`, which is `sag_level*8` with the default widths.
- R3: `sag_n` goes to 0 two cycles after the strobe that ends the Nth consecutive half cycle whose peak is below the threshold. N is `sag_cycles`, and a value of 0 acts as 1. `sag_flag` is set in the same cycle.
- R4: A half cycle whose peak is at or above the threshold clears the low-half-cycle count. `sag_n` then returns to 1 two cycles after the strobe that ended that half cycle, provided the timeout has not expired.
- R5: The crossing countdown is loaded from `zx_reload` during reset and at every positive-going crossing. It steps down by one on each `tick` while it is non-zero, and it then holds at 0 until the next positive crossing. While it is 0, `sag_n` is 0. A reload and a tick in the same cycle give the reload.
- R6: `sag_flag` is set on entry to a sag. `zxto_flag` is set when a tick brings the countdown from 1 to 0. Both flags stay set until `clr`, and a set in the same cycle as `clr` wins.
- R7: After reset `zx_out`, `sag_flag` and `zxto_flag` are 0, and `sag_n` is 1 when `zx_reload` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed voltage sample |
| sag_level | input | LEVEL_W | Sag amplitude level |
| sag_cycles | input | CYC_W | Low half cycles needed for a sag |
| zx_reload | input | TMO_W | Crossing timeout reload value |
| tick | input | 1 | Time-base tick for the timeout |
| clr | input | 1 | Clears both status flags |
| zx_out | output | 1 | Zero-cross output, high during the positive half |
| sag_n | output | 1 | Active-low sag output |
| sag_flag | output | 1 | Sticky sag event flag |
| zxto_flag | output | 1 | Sticky crossing timeout flag |

## Verification
The assertions take for granted that `smp_vld`, `tick` and `clr` are single-cycle strobes. They also assume that `sag_level`, `sag_cycles` and `zx_reload` do not change while a half cycle is being judged or a reload is in flight. Under those assumptions a fall of `sag_n` can be traced to a half-cycle end, a tick or a reload in the previous cycle. The bench changes configuration only between scenarios, when no strobe is pending. It raises each strobe for exactly one cycle, on the falling clock edge.

// File: rtl/sagmon_pkg.sv
package sagmon_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_LEVEL_W  = 12;
    localparam int DEF_CYC_W    = 8;
    localparam int DEF_TMO_W    = 16;

    // events produced when a half cycle closes
    typedef struct packed {
        logic hc_end;   // a sign change closed a half cycle
        logic pos_x;    // that change went from negative to non-negative
    } cross_t;

    typedef enum logic {
        SAG_IDLE   = 1'b0,
        SAG_ACTIVE = 1'b1
    } sag_state_t;

endpackage

// File: rtl/sagmon_halfcyc.sv
module sagmon_halfcyc
    import sagmon_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    output cross_t              ev,
    output logic [SAMPLE_W-1:0] peak,
    output logic                zx_lvl
);
    localparam int MSB = SAMPLE_W - 1;

    logic                primed;
    logic                prev_neg;
    logic                cur_neg;
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] run_peak;

    always_comb begin
        cur_neg = smp_data[MSB];
        mag     = cur_neg ? SAMPLE_W'(~smp_data + 1'b1) : smp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            prev_neg <= 1'b0;
            run_peak <= '0;
            ev       <= '0;
            peak     <= '0;
            zx_lvl   <= 1'b0;
        end else begin
            ev <= '0;
            if (smp_vld) begin
                if (!primed) begin
                    primed   <= 1'b1;
                    prev_neg <= cur_neg;
                    run_peak <= mag;
                end else if (cur_neg != prev_neg) begin
                    ev.hc_end <= 1'b1;
                    ev.pos_x  <= prev_neg;
                    peak      <= run_peak;
                    run_peak  <= mag;
                    prev_neg  <= cur_neg;
                    zx_lvl    <= prev_neg;
                end else if (mag > run_peak) begin
                    run_peak <= mag;
                end
            end
        end
    end

endmodule

// File: rtl/sagmon_qual.sv
module sagmon_qual
    import sagmon_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int LEVEL_W  = DEF_LEVEL_W,
    parameter int CYC_W    = DEF_CYC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hc_end,
    input  logic [SAMPLE_W-1:0] peak,
    input  logic [LEVEL_W-1:0]  sag_level,
    input  logic [CYC_W-1:0]    sag_cycles,
    output logic                sag_low,
    output logic                sag_evt
);
    localparam int SHIFT = SAMPLE_W - 1 - LEVEL_W;

    sag_state_t          state;
    logic [CYC_W-1:0]    cnt;
    logic [CYC_W-1:0]    cnt_inc;
    logic [CYC_W-1:0]    target;
    logic [SAMPLE_W-1:0] thr;
    logic                is_low;
    logic                reach;

    always_comb begin
        thr     = SAMPLE_W'(sag_level) << SHIFT;
        is_low  = peak < thr;
        cnt_inc = (cnt == '1) ? cnt : cnt + 1'b1;
        target  = (sag_cycles == '0) ? CYC_W'(1) : sag_cycles;
        reach   = cnt_inc >= target;
        sag_evt = hc_end && is_low && reach && (state == SAG_IDLE);
        sag_low = (state == SAG_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SAG_IDLE;
            cnt   <= '0;
        end else if (hc_end) begin
            if (is_low) begin
                cnt <= cnt_inc;
                if (reach) state <= SAG_ACTIVE;
            end else begin
                cnt   <= '0;
                state <= SAG_IDLE;
            end
        end
    end

endmodule

// File: rtl/sagmon_tmo.sv
module sagmon_tmo
    import sagmon_pkg::*;
#(
    parameter int TMO_W = DEF_TMO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMO_W-1:0] reload_val,
    input  logic             zx_pos,
    input  logic             tick,
    output logic [TMO_W-1:0] cnt,
    output logic             expired,
    output logic             to_evt
);
    always_comb begin
        expired = (cnt == '0);
        to_evt  = tick && !zx_pos && (cnt == TMO_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || zx_pos) cnt <= reload_val;
        else if (tick && !expired) cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/line_sag_monitor.sv
module line_sag_monitor
    import sagmon_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int LEVEL_W  = DEF_LEVEL_W,
    parameter int CYC_W    = DEF_CYC_W,
    parameter int TMO_W    = DEF_TMO_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LEVEL_W-1:0]  sag_level,
    input  logic [CYC_W-1:0]    sag_cycles,
    input  logic [TMO_W-1:0]    zx_reload,
    input  logic                tick,
    input  logic                clr,
    output logic                zx_out,
    output logic                sag_n,
    output logic                sag_flag,
    output logic                zxto_flag
);
    cross_t              hc_ev;
    logic [SAMPLE_W-1:0] hc_peak;
    logic                hc_end_w;
    logic                pos_x_w;
    logic                sag_low;
    logic                sag_evt;
    logic [TMO_W-1:0]    tmo_cnt;
    logic                tmo_expired;
    logic                tmo_evt;

    sagmon_halfcyc #(.SAMPLE_W(SAMPLE_W)) u_halfcyc (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .ev(hc_ev), .peak(hc_peak), .zx_lvl(zx_out)
    );

    assign hc_end_w = hc_ev.hc_end;
    assign pos_x_w  = hc_ev.pos_x;

    sagmon_qual #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .CYC_W(CYC_W)) u_qual (
        .clk(clk), .rst(rst), .hc_end(hc_end_w), .peak(hc_peak),
        .sag_level(sag_level), .sag_cycles(sag_cycles),
        .sag_low(sag_low), .sag_evt(sag_evt)
    );

    sagmon_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk(clk), .rst(rst), .reload_val(zx_reload), .zx_pos(pos_x_w),
        .tick(tick), .cnt(tmo_cnt), .expired(tmo_expired), .to_evt(tmo_evt)
    );

    assign sag_n = !(sag_low || tmo_expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            sag_flag  <= 1'b0;
            zxto_flag <= 1'b0;
        end else begin
            if (sag_evt)  sag_flag <= 1'b1;
            else if (clr) sag_flag <= 1'b0;
            if (tmo_evt)  zxto_flag <= 1'b1;
            else if (clr) zxto_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sagmon_checker.sv
module sagmon_checker #(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             tick,
    input logic             clr,
    input logic             zx_out,
    input logic             sag_n,
    input logic             sag_flag,
    input logic             zxto_flag,
    input logic             hc_end,
    input logic             pos_x,
    input logic [TMO_W-1:0] tmo_cnt
);
    p_zx_rise_after_sample_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(zx_out) |-> $past(smp_vld));

    p_zx_fall_after_sample_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(zx_out) |-> $past(smp_vld));

    p_sag_entry_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sag_n) |-> ($past(hc_end) || $past(tick) || $past(pos_x)));

    p_tmo_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (tmo_cnt == '0 && !pos_x) |=> (tmo_cnt == '0));

    p_tmo_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!pos_x && !tick) |=> $stable(tmo_cnt));

    p_sag_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (sag_flag && !clr) |=> sag_flag);

    p_zxto_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (zxto_flag && !clr) |=> zxto_flag);

    p_zxto_with_sag_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(zxto_flag) |-> !sag_n);

endmodule

bind line_sag_monitor sagmon_checker #(.TMO_W(TMO_W)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .tick(tick), .clr(clr),
    .zx_out(zx_out), .sag_n(sag_n), .sag_flag(sag_flag), .zxto_flag(zxto_flag),
    .hc_end(hc_end_w), .pos_x(pos_x_w), .tmo_cnt(tmo_cnt)
);

// File: tb/test_line_sag_monitor.sv
module test_line_sag_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_data = '0;
    logic [11:0] sag_level = 12'd100;   // threshold 800
    logic [7:0]  sag_cycles = 8'd3;
    logic [15:0] zx_reload = 16'd5;
    logic        tick = 1'b0;
    logic        clr = 1'b0;
    logic        zx_out, sag_n, sag_flag, zxto_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_sag_monitor i_line_sag_monitor (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .sag_level(sag_level), .sag_cycles(sag_cycles), .zx_reload(zx_reload),
        .tick(tick), .clr(clr), .zx_out(zx_out), .sag_n(sag_n),
        .sag_flag(sag_flag), .zxto_flag(zxto_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int v);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = 16'(v);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 zx_out after reset", zx_out, 0);
        chk("R7 sag_n after reset", sag_n, 1);
        chk("R7 sag_flag after reset", sag_flag, 0);
        chk("R7 zxto_flag after reset", zxto_flag, 0);
    endtask

    task automatic t_zero_cross();
        send(2000);
        chk("R1 first sample no crossing", zx_out, 0);
        send(-2000);
        chk("R1 negative half", zx_out, 0);
        send(2000);
        chk("R1 positive crossing", zx_out, 1);
        send(2500);
        chk("R1 same half holds", zx_out, 1);
        send(-2000);
        chk("R1 negative crossing", zx_out, 0);
        chk("R4 large swing no sag", sag_n, 1);
    endtask

    task automatic t_sag_entry();
        send(50);      // closes the 2000 half
        send(-50);     // low half 1
        chk("R3 one low half", sag_n, 1);
        send(799);     // low half 2
        chk("R3 two low halves", sag_n, 1);
        chk("R3 no flag yet", sag_flag, 0);
        send(-799);    // low half 3
        chk("R3 sag after three low halves", sag_n, 0);
        chk("R3 sag_flag set", sag_flag, 1);
    endtask

    task automatic t_recover();
        send(800);     // closes the 799 half, still low
        chk("R2 sag holds", sag_n, 0);
        send(100);     // same half, peak stays 800
        send(-5);      // closes a half with peak 800, at threshold
        chk("R2 R4 peak at threshold ends sag", sag_n, 1);
        chk("R6 sag_flag sticky", sag_flag, 1);
    endtask

    task automatic t_clear();
        pulse_clr();
        chk("R6 sag_flag cleared", sag_flag, 0);
        chk("R6 zxto_flag stays clear", zxto_flag, 0);
    endtask

    task automatic t_cycles_zero();
        sag_cycles = 8'd0;
        send(5);       // closes a half with peak 5
        chk("R3 zero count acts as one", sag_n, 0);
        chk("R3 flag with zero count", sag_flag, 1);
        send(-3000);
        chk("R3 low half keeps sag", sag_n, 0);
        send(3000);    // closes the 3000 half
        chk("R4 high half ends sag", sag_n, 1);
        sag_cycles = 8'd3;
        pulse_clr();
    endtask

    task automatic t_timeout();
        send(-3000);
        send(3000);    // positive crossing reloads 5
        pulse_tick(4);
        chk("R5 count not yet zero", sag_n, 1);
        chk("R6 no timeout flag yet", zxto_flag, 0);
        pulse_tick(1);
        chk("R5 expiry drives sag_n low", sag_n, 0);
        chk("R6 zxto_flag set", zxto_flag, 1);
        pulse_tick(3);
        chk("R5 holds at zero", sag_n, 0);
        send(-3000);
        chk("R5 negative crossing no reload", sag_n, 0);
        send(3000);
        chk("R5 positive crossing reloads", sag_n, 1);
        chk("R6 zxto_flag sticky", zxto_flag, 1);
        pulse_clr();
        chk("R6 zxto_flag cleared", zxto_flag, 0);
    endtask

    task automatic t_set_beats_clear();
        send(-3000);
        send(3000);    // reload 5
        pulse_tick(4);
        @(negedge clk);
        tick = 1'b1;
        clr  = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        clr  = 1'b0;
        @(negedge clk);
        chk("R6 set wins over clear", zxto_flag, 1);
        chk("R5 expired with clear", sag_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_cross();
        t_sag_entry();
        t_recover();
        t_clear();
        t_cycles_zero();
        t_timeout();
        t_set_beats_clear();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule